// File: doc/BRIEF.md
# Thermal Event and Throttle Request Controller

This block gathers thermal events for a device with two cores. Each core raises an over-temperature trip. The platform can also force throttling through an input that is asynchronous to the block clock. The block resynchronizes these inputs and ORs the core trips together. It drives an active-low hot indication pin, which reflects only the core trips. It also raises one throttle request that is shared by both cores.

Throttling follows the hot indication and the platform force input, but only while the thermal-monitor enable is set. The platform force input never drives the hot indication.

Both edges of the hot indication are recorded in sticky status flags. Software clears a flag by writing 1 to it. A level interrupt is raised whenever a recorded edge has its own enable bit set.

Top module: `thermal_event_ctrl`

## Requirements
- R1: After reset, hotN is 1, throttleReq is 0, irq is 0 and status is 0.
- R2: hotN is 0 exactly when at least one bit of coreTrip is 1. The hotN pin changes after the third rising clock edge following a coreTrip change.
- R3: platformForce never affects hotN.
- R4: With monEnable at 1, throttleReq is 1 when hotN is low or platformForce is high. A force change reaches throttleReq after the third edge. A trip change reaches throttleReq after the fourth edge.
- R5: With monEnable at 0, throttleReq is 0 whatever coreTrip and platformForce do.
- R6: A falling edge of hotN sets status bit 0 one edge after hotN falls.
- R7: A rising edge of hotN sets status bit 1 one edge after hotN rises.
- R8: An edge with clrWrite at 1 clears each status bit whose clrData bit (same position) is 1. Bits whose clrData bit is 0 keep their value.
- R9: A clear and a set of the same status bit at the same edge leave the bit at 1.
- R10: irq is 1 exactly when (status bit 0 and intEnAssert) or (status bit 1 and intEnDeassert).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset |
| coreTrip | input | NUM_CORES | Per-core over-temperature trip, asynchronous |
| platformForce | input | 1 | Platform throttle force, active high, asynchronous |
| monEnable | input | 1 | Thermal-monitor enable |
| intEnAssert | input | 1 | Interrupt enable for the hot assertion flag |
| intEnDeassert | input | 1 | Interrupt enable for the hot de-assertion flag |
| clrWrite | input | 1 | Status clear write strobe |
| clrData | input | 2 | Write-1-to-clear mask; bit 0 = assertion flag, bit 1 = de-assertion flag |
| hotN | output | 1 | Hot indication, active low |
| throttleReq | output | 1 | Thermal-control request to both cores |
| irq | output | 1 | Level interrupt |
| status | output | 2 | Sticky flags; bit 0 = hot asserted, bit 1 = hot de-asserted |

## Verification
The assertions check on every cycle that throttling stays off while the monitor is disabled. They also check that a hot level with the monitor enabled forces throttling, that hot never rises without a synchronized trip, that each hot edge sets its flag, that flags hold until cleared, and that an unopposed clear takes effect.

Only the bench scenarios show the other properties. These are the exact pipeline latencies and the fact that the force input leaves the hot pin untouched across every trip/force/enable combination. They also include the interrupt level for each pairing of enables with recorded edges, and set-over-clear priority when both happen on the same edge.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  typedef struct packed {
    logic hotRise;
    logic hotFall;
  } hotEvt_t;

  localparam int STAT_W      = 2;
  localparam int ST_ASSERT   = 0;
  localparam int ST_DEASSERT = 1;
endpackage

// File: rtl/thermal_datapath.sv
module thermal_datapath
  import thermal_pkg::*;
#(
  parameter int NUM_CORES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CORES-1:0] coreTrip,
  input  logic                 platformForce,
  output logic                 hotLevel,
  output logic                 forceLevel,
  output hotEvt_t              evt
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] tripChain [NUM_CORES];
  logic [NUM_CORES-1:0]   tripSyncd;
  logic [SYNC_STAGES-1:0] forceChain;
  logic                   hotReg;
  logic                   hotPrev;

  for (genvar c = 0; c < NUM_CORES; c++) begin : gTripSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) tripChain[c] <= '0;
      else       tripChain[c] <= {tripChain[c][SYNC_STAGES-2:0], coreTrip[c]};
    end
    assign tripSyncd[c] = tripChain[c][LAST];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) forceChain <= '0;
    else       forceChain <= {forceChain[SYNC_STAGES-2:0], platformForce};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hotReg  <= 1'b0;
      hotPrev <= 1'b0;
    end else begin
      hotReg  <= |tripSyncd;
      hotPrev <= hotReg;
    end
  end

  assign hotLevel    = hotReg;
  assign forceLevel  = forceChain[LAST];
  assign evt.hotRise = hotReg & ~hotPrev;
  assign evt.hotFall = ~hotReg & hotPrev;

  AST_HOT_NEEDS_TRIP: assert property (@(posedge clk) disable iff (!rstN)
    hotLevel |-> $past(|tripSyncd)) else $error("hot without trip"); // R2

endmodule

// File: rtl/thermal_ctrl.sv
module thermal_ctrl
  import thermal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              monEnable,
  input  logic              hotLevel,
  input  logic              forceLevel,
  input  hotEvt_t           evt,
  input  logic              intEnAssert,
  input  logic              intEnDeassert,
  input  logic              clrWrite,
  input  logic [STAT_W-1:0] clrData,
  output logic              throttleReq,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [STAT_W-1:0] setVec;
  logic [STAT_W-1:0] clrVec;
  logic [STAT_W-1:0] enVec;

  always_comb begin
    setVec              = '0;
    setVec[ST_ASSERT]   = evt.hotRise;
    setVec[ST_DEASSERT] = evt.hotFall;
    clrVec              = clrWrite ? clrData : '0;
    enVec               = '0;
    enVec[ST_ASSERT]    = intEnAssert;
    enVec[ST_DEASSERT]  = intEnDeassert;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status      <= '0;
      throttleReq <= 1'b0;
    end else begin
      status      <= (status & ~clrVec) | setVec;
      throttleReq <= monEnable & (hotLevel | forceLevel);
    end
  end

  assign irq = |(status & enVec);

  AST_THROTTLE_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !monEnable |=> !throttleReq) else $error("throttle while disabled"); // R5
  AST_THROTTLE_ON_HOT: assert property (@(posedge clk) disable iff (!rstN)
    (monEnable && hotLevel) |=> throttleReq) else $error("hot not throttled"); // R4
  AST_RISE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    evt.hotRise |=> status[ST_ASSERT]) else $error("rise not flagged"); // R6
  AST_FALL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    evt.hotFall |=> status[ST_DEASSERT]) else $error("fall not flagged"); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (status[ST_ASSERT] && !(clrWrite && clrData[ST_ASSERT])) |=> status[ST_ASSERT])
    else $error("flag lost"); // R8
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrite && clrData[ST_DEASSERT] && !evt.hotFall) |=> !status[ST_DEASSERT])
    else $error("clear ignored"); // R8

endmodule

// File: rtl/thermal_event_ctrl.sv
module thermal_event_ctrl
  import thermal_pkg::*;
#(
  parameter int NUM_CORES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CORES-1:0] coreTrip,
  input  logic                 platformForce,
  input  logic                 monEnable,
  input  logic                 intEnAssert,
  input  logic                 intEnDeassert,
  input  logic                 clrWrite,
  input  logic [STAT_W-1:0]    clrData,
  output logic                 hotN,
  output logic                 throttleReq,
  output logic                 irq,
  output logic [STAT_W-1:0]    status
);
  logic    hotLevel;
  logic    forceLevel;
  hotEvt_t evt;

  thermal_datapath #(.NUM_CORES(NUM_CORES), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .coreTrip(coreTrip), .platformForce(platformForce),
    .hotLevel(hotLevel), .forceLevel(forceLevel), .evt(evt)
  );

  thermal_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .monEnable(monEnable), .hotLevel(hotLevel),
    .forceLevel(forceLevel), .evt(evt), .intEnAssert(intEnAssert),
    .intEnDeassert(intEnDeassert), .clrWrite(clrWrite), .clrData(clrData),
    .throttleReq(throttleReq), .status(status), .irq(irq)
  );

  assign hotN = ~hotLevel;

endmodule

// File: tb/tb_thermal_event_ctrl.sv
`timescale 1ns/1ps
module tb_thermal_event_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] coreTrip = '0;
  logic       platformForce = 1'b0;
  logic       monEnable = 1'b0;
  logic       intEnAssert = 1'b0;
  logic       intEnDeassert = 1'b0;
  logic       clrWrite = 1'b0;
  logic [1:0] clrData = '0;
  logic       hotN, throttleReq, irq;
  logic [1:0] status;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  thermal_event_ctrl dut (
    .clk(clk), .rstN(rstN), .coreTrip(coreTrip), .platformForce(platformForce),
    .monEnable(monEnable), .intEnAssert(intEnAssert), .intEnDeassert(intEnDeassert),
    .clrWrite(clrWrite), .clrData(clrData), .hotN(hotN), .throttleReq(throttleReq),
    .irq(irq), .status(status)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearAll();
    clrWrite = 1'b1; clrData = 2'b11;
    tick(1);
    clrWrite = 1'b0; clrData = 2'b00;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tick(2);
    check("R1 hotN", hotN, 1);
    check("R1 throttle", throttleReq, 0);
    check("R1 irq", irq, 0);
    check("R1 status", status, 0);
    rstN = 1'b1;
    tick(1);

    // R2 R3 R4 R5: sweep trips x force x enable
    for (int m = 0; m < 2; m++)
      for (int f = 0; f < 2; f++)
        for (int t = 0; t < 4; t++) begin
          monEnable = m[0]; platformForce = f[0]; coreTrip = t[1:0];
          tick(6);
          check(f ? "R3 hotN" : "R2 hotN", hotN, (t != 0) ? 0 : 1);
          check(m ? "R4 throttle" : "R5 throttle", throttleReq,
                (m != 0 && (t != 0 || f != 0)) ? 1 : 0);
        end

    // latency of trip path, R2 R4
    coreTrip = 0; platformForce = 0; monEnable = 1;
    tick(6); clearAll();
    coreTrip = 2'b01;
    tick(2);
    check("R2 latency early", hotN, 1);
    tick(1);
    check("R2 latency", hotN, 0);
    check("R4 trip early", throttleReq, 0);
    tick(1);
    check("R4 trip latency", throttleReq, 1);
    check("R6 flag", status[0], 1);
    coreTrip = 0; tick(6); clearAll();

    // force latency R4
    platformForce = 1;
    tick(2);
    check("R4 force early", throttleReq, 0);
    tick(1);
    check("R4 force latency", throttleReq, 1);
    check("R3 hotN with force", hotN, 1);
    platformForce = 0; tick(6);

    // R6 R7 R8 R10 across enables
    for (int e = 0; e < 4; e++) begin
      intEnAssert = e[0]; intEnDeassert = e[1];
      clearAll(); tick(1);
      check("R10 idle", irq, 0);
      coreTrip = 2'b10; tick(5);
      check("R6 set", status, 1);
      check("R10 rise", irq, e[0]);
      coreTrip = 0; tick(5);
      check("R7 set", status, 3);
      check("R10 both", irq, (e != 0) ? 1 : 0);
      clrWrite = 1; clrData = 2'b01; tick(1); clrWrite = 0; clrData = 0;
      check("R8 clear bit0", status, 2);
      check("R10 fall", irq, e[1]);
      clrWrite = 1; clrData = 2'b00; tick(1); clrWrite = 0;
      check("R8 zero mask", status, 2);
      clrWrite = 1; clrData = 2'b10; tick(1); clrWrite = 0; clrData = 0;
      check("R8 clear bit1", status, 0);
      check("R10 cleared", irq, 0);
    end

    // R9 set beats clear on the same edge
    clearAll(); tick(1);
    coreTrip = 2'b11;
    tick(3);
    clrWrite = 1; clrData = 2'b11;
    tick(1);
    clrWrite = 0; clrData = 0;
    check("R9 set wins", status[0], 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule